// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

The controller gathers 64 level-sensitive request lines into a pending register that tracks each line on every clock. A source takes part in arbitration when it is pending or forced, enabled, and not masked. A source is enabled by writing a nonzero priority byte for it and disabled by writing zero. Among the active sources, the one with the largest priority byte wins. On equal priority the higher-numbered source wins. The winner's priority is presented as the interrupt level, and 64 plus its index is presented as the vector number. With no active source the level is 0 and the vector is 24.

Software reaches the block through a simple byte-addressed register port. Writes use a strobe. Reads are combinational from the address. The 64-bit pending, mask and force registers can be read in 32-bit halves. The mask can be rewritten half at a time, or changed one bit at a time (or all at once) through two command offsets. A read at 0xE0 returns the vector currently presented to the processor, which serves as the software acknowledge. The force register has no write path, so it stays at its reset value of zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source is active exactly when (pending OR force) AND enabled AND NOT masked.
- R2: The priority byte of source i lives at offset 0x40+i and reads back in bits 7:0. Writing zero clears the source's enable, and writing a nonzero value sets it.
- R3: The winner is the active source with the largest priority byte. On a tie, the higher source index wins.
- R4: The level equals the winner's priority byte and the vector equals 64 plus the winner's index. With no active source, the level is 0 and the vector is 24. Both outputs are registered and follow a state change by one clock.
- R5: Reads return the following. Offsets 0x00/0x04 give pending bits 63:32/31:0. Offsets 0x08/0x0C give the same halves of the mask. Offsets 0x10/0x14 give the same halves of force. Offset 0xE0 gives the current vector. Any other offset reads 0.
- R6: A write to 0x08 replaces mask bits 63:32 and a write to 0x0C replaces mask bits 31:0. Writes to 0x00 and 0x04 are ignored and raise no error.
- R7: A write to 0x1C sets every mask bit when data bit 6 is 1. Otherwise it sets the single mask bit indexed by data bits 5:0.
- R8: A write to 0x1D clears every mask bit when data bit 6 is 1. Otherwise it clears the single mask bit indexed by data bits 5:0.
- R9: Reset (rst_n low at a clock edge) gives the following values: mask all ones; pending, force, enables and priority bytes zero; level 0; vector 24.
- R10: Each pending bit takes the level of its request line at every clock edge.
- R11: A write to any other offset, including 0x10/0x14, changes no state. It raises wr_err for exactly the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Level-sensitive request lines |
| reg_wr | input | 1 | Write strobe, one write per clock with it high |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_level | output | 8 | Presented interrupt level |
| irq_vector | output | 8 | Presented vector number |
| wr_err | output | 1 | One-cycle flag for a write to an unsupported offset |

## Verification
The embedded assertions check, on every cycle, several relations between state and outputs. Pending always equals the request lines of the previous clock. An idle level always comes with vector 24, and a nonzero level always comes with a vector of 64 or above. Each global set-mask or clear-mask command fills or empties the mask. A flagged bad write leaves the mask untouched. The arbitration order needs scenarios to show it. This covers tie breaking towards the higher index, disabling through a zero priority byte, and the way single-bit and half-register mask writes change the winner. Read decode and the unlisted-offset zero also need scenarios. The bench table walks these through a sequence of writes with known expected level and vector.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC     = 64,
  parameter int PW       = 8,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int VW       = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_IDLE = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [PW-1:0]   irq_level,
  output logic [VW-1:0]   irq_vector,
  output logic            wr_err
);
  localparam int IW    = $clog2(NSRC);
  localparam int HALF  = NSRC / 2;
  localparam int NODES = 2 * NSRC;

  localparam logic [AW-1:0] A_PEND_HI = AW'('h00);
  localparam logic [AW-1:0] A_PEND_LO = AW'('h04);
  localparam logic [AW-1:0] A_MASK_HI = AW'('h08);
  localparam logic [AW-1:0] A_MASK_LO = AW'('h0C);
  localparam logic [AW-1:0] A_FRC_HI  = AW'('h10);
  localparam logic [AW-1:0] A_FRC_LO  = AW'('h14);
  localparam logic [AW-1:0] A_MSET    = AW'('h1C);
  localparam logic [AW-1:0] A_MCLR    = AW'('h1D);
  localparam logic [AW-1:0] A_VEC     = AW'('hE0);

  logic [NSRC-1:0] pend_q, mask_q, frc_q, en_q, act;
  logic [PW-1:0]   pri_q [NSRC];
  logic [PW-1:0]   lvl_q;
  logic [VW-1:0]   vec_q;
  logic            err_q;

  wire is_pri  = reg_addr[AW-1:IW] == (AW-IW)'(1);
  wire is_ign  = reg_addr == A_PEND_HI || reg_addr == A_PEND_LO;
  wire is_mhi  = reg_addr == A_MASK_HI;
  wire is_mlo  = reg_addr == A_MASK_LO;
  wire is_mset = reg_addr == A_MSET;
  wire is_mclr = reg_addr == A_MCLR;
  wire is_bad  = reg_wr & ~(is_pri | is_ign | is_mhi | is_mlo | is_mset | is_mclr);
  wire cmd_all = reg_wdata[6];
  wire [NSRC-1:0] cmd_bit = NSRC'(1) << reg_wdata[IW-1:0];
  wire [IW-1:0]   pri_idx = reg_addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      frc_q  <= '0;
    end else begin
      pend_q <= irq_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (reg_wr) begin
      if (is_mhi)
        mask_q[NSRC-1:HALF] <= reg_wdata[HALF-1:0];
      else if (is_mlo)
        mask_q[HALF-1:0] <= reg_wdata[HALF-1:0];
      else if (is_mset)
        mask_q <= cmd_all ? '1 : (mask_q | cmd_bit);
      else if (is_mclr)
        mask_q <= cmd_all ? '0 : (mask_q & ~cmd_bit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NSRC; i++) pri_q[i] <= '0;
    end else if (reg_wr && is_pri) begin
      pri_q[pri_idx] <= reg_wdata[PW-1:0];
      en_q[pri_idx]  <= |reg_wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= is_bad;
  end

  assign act = (pend_q | frc_q) & en_q & ~mask_q;

  logic          nd_vld [1:NODES-1];
  logic [PW-1:0] nd_pri [1:NODES-1];
  logic [IW-1:0] nd_idx [1:NODES-1];

  for (genvar s = 0; s < NSRC; s++) begin : g_leaf
    assign nd_vld[NSRC+s] = act[s];
    assign nd_pri[NSRC+s] = pri_q[s];
    assign nd_idx[NSRC+s] = IW'(s);
  end

  for (genvar n = 1; n < NSRC; n++) begin : g_node
    wire take_hi = nd_vld[2*n+1] & (~nd_vld[2*n] | (nd_pri[2*n+1] >= nd_pri[2*n]));
    assign nd_vld[n] = nd_vld[2*n] | nd_vld[2*n+1];
    assign nd_pri[n] = take_hi ? nd_pri[2*n+1] : nd_pri[2*n];
    assign nd_idx[n] = take_hi ? nd_idx[2*n+1] : nd_idx[2*n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= VW'(VEC_IDLE);
    end else begin
      lvl_q <= nd_vld[1] ? nd_pri[1] : '0;
      vec_q <= nd_vld[1] ? VW'(VEC_BASE) + VW'(nd_idx[1]) : VW'(VEC_IDLE);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (is_pri) reg_rdata = DW'(pri_q[pri_idx]);
    else begin
      case (reg_addr)
        A_PEND_HI: reg_rdata = DW'(pend_q[NSRC-1:HALF]);
        A_PEND_LO: reg_rdata = DW'(pend_q[HALF-1:0]);
        A_MASK_HI: reg_rdata = DW'(mask_q[NSRC-1:HALF]);
        A_MASK_LO: reg_rdata = DW'(mask_q[HALF-1:0]);
        A_FRC_HI:  reg_rdata = DW'(frc_q[NSRC-1:HALF]);
        A_FRC_LO:  reg_rdata = DW'(frc_q[HALF-1:0]);
        A_VEC:     reg_rdata = DW'(vec_q);
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign irq_level  = lvl_q;
  assign irq_vector = vec_q;
  assign wr_err     = err_q;

  // R10
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend_q == $past(irq_in));

  // R4
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_vector == VW'(VEC_IDLE)));

  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != '0 |-> irq_vector >= VW'(VEC_BASE));

  // R7
  mset_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr && reg_addr == A_MSET && reg_wdata[6]) |-> mask_q == '1);

  // R8
  mclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr && reg_addr == A_MCLR && reg_wdata[6]) |-> mask_q == '0);

  // R11
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wr_err |-> $stable(mask_q) && $stable(en_q));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_level, irq_vector;
  logic        wr_err;

  int total = 0, bad = 0;
  logic err_seen;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_vector(irq_vector), .wr_err(wr_err)
  );

  always #(CLK_P/2) clk = ~clk;

  // addr, data, expected level, expected vector
  localparam logic [55:0] TBL [12] = '{
    {8'h45, 32'h0000_0003, 8'd3,   8'd69},
    {8'h49, 32'h0000_0003, 8'd3,   8'd73},
    {8'h42, 32'h0000_0007, 8'd7,   8'd66},
    {8'h1C, 32'h0000_0002, 8'd3,   8'd73},
    {8'h49, 32'h0000_0000, 8'd3,   8'd69},
    {8'h7F, 32'h0000_0001, 8'd3,   8'd69},
    {8'h1D, 32'h0000_0002, 8'd7,   8'd66},
    {8'h7F, 32'h0000_00FF, 8'd255, 8'd127},
    {8'h1C, 32'h0000_0040, 8'd0,   8'd24},
    {8'h1D, 32'h0000_0040, 8'd255, 8'd127},
    {8'h08, 32'h8000_0000, 8'd7,   8'd66},
    {8'h0C, 32'h0000_0004, 8'd3,   8'd69}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    err_seen = wr_err;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic out_chk(input string req, input logic [7:0] l, input logic [7:0] v);
    check(req, {16'h0, irq_level, irq_vector}, {16'h0, l, v});
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    out_chk("R9", 8'd0, 8'd24);
    rd(8'h08, r); check("R9 mask hi", r, 32'hFFFF_FFFF);
    rd(8'h0C, r); check("R9 mask lo", r, 32'hFFFF_FFFF);
    rd(8'h00, r); check("R9 pend hi", r, 32'h0);
    rd(8'h47, r); check("R9 prio", r, 32'h0);
    rd(8'hE0, r); check("R5 vec read", r, 32'd24);

    // R10 pending follows line, R5 split read
    irq_in = 64'h0000_0002_0000_0000;
    settle();
    rd(8'h00, r); check("R10 pend hi", r, 32'h2);
    rd(8'h04, r); check("R5 pend lo", r, 32'h0);
    // R1 pending but disabled and masked: idle
    out_chk("R1 idle", 8'd0, 8'd24);

    irq_in = '1;
    wr(8'h1D, 32'h40);
    settle();
    // R8 clear-all
    rd(8'h0C, r); check("R8 mask lo", r, 32'h0);
    // R1 enables still zero: no winner
    out_chk("R1 not enabled", 8'd0, 8'd24);

    // R2 R3 R4 R6 R7 R8 table walk
    for (int i = 0; i < 12; i++) begin
      wr(TBL[i][55:48], TBL[i][47:16]);
      settle();
      out_chk($sformatf("R3 row %0d", i), TBL[i][15:8], TBL[i][7:0]);
    end

    rd(8'h08, r); check("R6 mask hi", r, 32'h8000_0000);
    rd(8'h0C, r); check("R6 mask lo", r, 32'h4);
    rd(8'h45, r); check("R2 prio read", r, 32'h3);
    rd(8'h49, r); check("R2 zero prio", r, 32'h0);
    rd(8'hE0, r); check("R5 vec read", r, 32'd69);

    // R10 line dropped clears pending and the request
    irq_in = '0;
    settle();
    out_chk("R10 low line", 8'd0, 8'd24);
    irq_in = 64'h20;
    settle();
    out_chk("R10 high line", 8'd3, 8'd69);

    // R6 pending writes ignored, no error
    wr(8'h04, 32'h0);
    check("R6 no err", {31'h0, err_seen}, 32'h0);
    rd(8'h04, r); check("R6 pend kept", r, 32'h20);

    // R11 force write rejected
    wr(8'h10, 32'hFFFF_FFFF);
    check("R11 err pulse", {31'h0, err_seen}, 32'h1);
    @(negedge clk);
    check("R11 err one cycle", {31'h0, wr_err}, 32'h0);
    rd(8'h10, r); check("R11 force hi", r, 32'h0);
    rd(8'h14, r); check("R5 force lo", r, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R11 err other", {31'h0, err_seen}, 32'h1);
    rd(8'h0C, r); check("R11 mask kept", r, 32'h4);
    out_chk("R11 outputs kept", 8'd3, 8'd69);
    rd(8'h90, r); check("R5 unlisted", r, 32'h0);

    // R7 single set masks the winner
    wr(8'h1C, 32'h05);
    settle();
    out_chk("R7 single set", 8'd0, 8'd24);

    // R9 second reset
    rst_n = 1'b0;
    settle();
    rst_n = 1'b1;
    out_chk("R9 reset again", 8'd0, 8'd24);
    rd(8'h45, r); check("R9 prio cleared", r, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule